// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream sent to a two-bank double-data-rate SDRAM and keeps its own copy of the device state. Each clock it takes one decoded command, the bank address and the clock-enable (CKE) level. It tracks whether each bank is idle or open, and whether the device is in normal operation, power-down or self-refresh. A command that the device may not accept in its current state raises a registered flag. The tracker ignores illegal commands, so its state does not change.

A controller or a protocol monitor uses the tracker next to the memory interface. It catches illegal sequences as they happen and tells the data path when the data and strobe pins must float. Command legality depends on the CKE level sampled on the previous clock. Entry into low power depends on whether all banks are idle. After any CKE rise the tracker refuses commands for a short wake window. After self-refresh exit it refuses reads for a longer window. Beyond these CKE rules, the block counts no timing parameters.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The command code is decoded only when CKE was high at the previous clock edge. When CKE was low at the previous edge, the command is ignored: no flag is raised and no bank changes. The CKE history resets to low.
- R2: Activate (code 1) is legal only to a bank that is idle and not closing, and it opens that bank. Activate to an open bank is flagged. Legality is always judged on the bank named by the bank address.
- R3: Read (2), read with auto precharge (3), write (4) and write with auto precharge (5) need the addressed bank open and not closing. Otherwise they are flagged.
- R4: Precharge (6) closes the addressed bank and is accepted as a no-op when that bank is already idle. Precharge all (7) closes every bank. Both codes are always legal.
- R5: After a read or write with auto precharge, the bank stays open for BURST_CYCLES (default 2) further clock edges and is idle after the last of them. While it is closing, only precharge may address it. Burst stop (13) is flagged while any bank is closing.
- R6: Auto refresh (8), mode register set (11) and extended mode register set (12) are legal only when all banks are idle.
- R7: Self-refresh entry (9) is legal only when all banks are idle, and it moves the device to self-refresh. Self-refresh exit (10), when it is decoded as a normal command, is always flagged. In self-refresh with CKE high, every command except NOP (0) is flagged.
- R8: In normal mode, with no self-refresh entry accepted, a low CKE at a clock edge moves the device to power-down. A high CKE at a later edge returns it to normal. Mode encoding: 0 normal, 1 power-down, 2 self-refresh.
- R9: On each of the WAKE_CYCLES (default 2) clock edges after the edge where CKE is first seen high after being low, every command except NOP is flagged and not applied.
- R10: After self-refresh exit, reads are flagged on each of the READ_LOCK_CYCLES (default 200) clock edges that follow the exit edge. A read on the edge after that window is legal.
- R11: The data high-impedance enable is high whenever CKE is low or the device is not in normal mode.
- R12: The illegal flag is registered. It is high for exactly the cycle after the edge that took the offending command. An illegal command changes neither the bank state nor the mode.
- R13: While reset is asserted, and for two clock edges after it is released, all banks are idle, the mode is normal and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 4 | Decoded command code (see requirements) |
| ba_i | input | 1 | Bank address of the command |
| cke_i | input | 1 | Clock-enable level sent to the device |
| illegal_o | output | 1 | One-cycle pulse for each illegal command |
| dq_hiz_o | output | 1 | Data and strobe pins must be high impedance |
| bank_open_o | output | 2 | Per-bank open (1) or idle (0) state |
| mode_o | output | 2 | Device mode: 0 normal, 1 power-down, 2 self-refresh |

## Verification
The bound assertions check these on every cycle: high impedance while CKE is low, commands that follow a low CKE sample raise no flag, activate to an open bank is flagged, self-refresh is refused with an open bank, power-down entry from normal mode, and an illegal command leaves the mode alone. Only the bench scenarios can show these: the exact length of the auto-precharge close, the two-edge wake window, and the 200-edge read lockout with its last refused edge and first accepted edge. The same holds for the precharge no-op and for precharge-all cancelling a pending close. The bench reference model compares all four outputs on every clock.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PALL = 4'd7,
    CMD_REF  = 4'd8,
    CMD_SREF = 4'd9,
    CMD_SREX = 4'd10,
    CMD_MRS  = 4'd11,
    CMD_EMRS = 4'd12,
    CMD_BST  = 4'd13
  } sdt_cmd_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PDOWN  = 2'd1,
    MODE_SREF   = 2'd2
  } sdt_mode_e;

endpackage

// File: rtl/sdt_bank.sv
module sdt_bank #(
  parameter int BURST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic ap_i,
  input  logic close_i,
  output logic open_o,
  output logic closing_o
);

  localparam int CNT_W = $clog2(BURST_CYCLES + 1);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign closing_o = (cnt_q != '0);
  assign upd       = act_i | ap_i | close_i | closing_o;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (close_i) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else if (ap_i) begin
      cnt_d = CNT_W'(BURST_CYCLES);
    end else if (act_i) begin
      open_d = 1'b1;
    end else if (closing_o) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign open_o = open_q;

endmodule

// File: rtl/sdt_power_ctrl.sv
module sdt_power_ctrl
  import sdt_pkg::*;
#(
  parameter int WAKE_CYCLES      = 2,
  parameter int READ_LOCK_CYCLES = 200
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke_i,
  input  logic      sref_go_i,
  output sdt_mode_e mode_o,
  output logic      cke_q_o,
  output logic      gate_busy_o,
  output logic      read_lock_o
);

  localparam int GATE_W = $clog2(WAKE_CYCLES + 1);
  localparam int LOCK_W = $clog2(READ_LOCK_CYCLES + 1);

  sdt_mode_e         mode_q, mode_d;
  logic              cke_q;
  logic [GATE_W-1:0] gate_q, gate_d;
  logic [LOCK_W-1:0] lock_q, lock_d;
  logic              cke_rise;

  assign cke_rise = ~cke_q & cke_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL: begin
        if (sref_go_i)   mode_d = MODE_SREF;
        else if (!cke_i) mode_d = MODE_PDOWN;
      end
      MODE_PDOWN: if (cke_i) mode_d = MODE_NORMAL;
      MODE_SREF:  if (cke_rise) mode_d = MODE_NORMAL;
      default:    mode_d = MODE_NORMAL;
    endcase
  end

  always_comb begin
    if (cke_rise)              gate_d = GATE_W'(WAKE_CYCLES);
    else if (gate_q != '0)     gate_d = gate_q - GATE_W'(1);
    else                       gate_d = gate_q;
    if (mode_q == MODE_SREF && cke_rise) lock_d = LOCK_W'(READ_LOCK_CYCLES);
    else if (lock_q != '0)               lock_d = lock_q - LOCK_W'(1);
    else                                 lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      cke_q  <= 1'b0;
      gate_q <= '0;
      lock_q <= '0;
    end else begin
      mode_q <= mode_d;
      cke_q  <= cke_i;
      if (cke_rise || gate_q != '0) gate_q <= gate_d;
      if (cke_rise || lock_q != '0) lock_q <= lock_d;
    end
  end

  assign mode_o      = mode_q;
  assign cke_q_o     = cke_q;
  assign gate_busy_o = (gate_q != '0);
  assign read_lock_o = (lock_q != '0);

endmodule

// File: rtl/sdt_cmd_check.sv
module sdt_cmd_check
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input  sdt_cmd_e             cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 cke_q_i,
  input  logic                 gate_busy_i,
  input  sdt_mode_e            mode_i,
  input  logic                 read_lock_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] closing_i,
  output logic                 illegal_o,
  output logic                 accept_o,
  output logic                 sref_go_o
);

  logic all_idle, any_closing, tgt_open, tgt_closing, not_ready;

  assign all_idle    = ~|open_i;
  assign any_closing = |closing_i;
  assign tgt_open    = open_i[ba_i];
  assign tgt_closing = closing_i[ba_i];
  assign not_ready   = ~tgt_open | tgt_closing;

  always_comb begin
    illegal_o = 1'b0;
    accept_o  = 1'b0;
    if (cke_q_i) begin
      if (gate_busy_i || mode_i != MODE_NORMAL) begin
        illegal_o = (cmd_i != CMD_NOP);
      end else begin
        unique case (cmd_i)
          CMD_NOP:                    illegal_o = 1'b0;
          CMD_ACT:                    illegal_o = tgt_open;
          CMD_RD, CMD_RDA:            illegal_o = not_ready | read_lock_i;
          CMD_WR, CMD_WRA:            illegal_o = not_ready;
          CMD_PRE, CMD_PALL:          illegal_o = 1'b0;
          CMD_REF, CMD_SREF,
          CMD_MRS, CMD_EMRS:          illegal_o = ~all_idle;
          CMD_SREX:                   illegal_o = 1'b1;
          CMD_BST:                    illegal_o = any_closing;
          default:                    illegal_o = 1'b1;
        endcase
        accept_o = ~illegal_o & (cmd_i != CMD_NOP);
      end
    end
  end

  assign sref_go_o = accept_o & (cmd_i == CMD_SREF);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS        = 2,
  parameter int BURST_CYCLES     = 2,
  parameter int WAKE_CYCLES      = 2,
  parameter int READ_LOCK_CYCLES = 200,
  localparam int BA_W            = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 cke_i,
  output logic                 illegal_o,
  output logic                 dq_hiz_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [1:0]           mode_o
);

  logic [1:0]           rst_pipe;
  logic                 rst_n_sync;
  sdt_cmd_e             cmd;
  sdt_mode_e            mode;
  logic                 cke_q, gate_busy, read_lock;
  logic                 bad, accept, sref_go;
  logic                 illegal_q;
  logic [NUM_BANKS-1:0] open_v, closing_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  assign cmd = sdt_cmd_e'(cmd_i);

  sdt_power_ctrl #(
    .WAKE_CYCLES      (WAKE_CYCLES),
    .READ_LOCK_CYCLES (READ_LOCK_CYCLES)
  ) u_power (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cke_i       (cke_i),
    .sref_go_i   (sref_go),
    .mode_o      (mode),
    .cke_q_o     (cke_q),
    .gate_busy_o (gate_busy),
    .read_lock_o (read_lock)
  );

  sdt_cmd_check #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_check (
    .cmd_i       (cmd),
    .ba_i        (ba_i),
    .cke_q_i     (cke_q),
    .gate_busy_i (gate_busy),
    .mode_i      (mode),
    .read_lock_i (read_lock),
    .open_i      (open_v),
    .closing_i   (closing_v),
    .illegal_o   (bad),
    .accept_o    (accept),
    .sref_go_o   (sref_go)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel, act_s, ap_s, close_s;
    assign sel     = (ba_i == BA_W'(b));
    assign act_s   = accept & sel & (cmd == CMD_ACT);
    assign ap_s    = accept & sel & (cmd == CMD_RDA || cmd == CMD_WRA);
    assign close_s = accept & ((sel & (cmd == CMD_PRE)) | (cmd == CMD_PALL));

    sdt_bank #(
      .BURST_CYCLES (BURST_CYCLES)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .act_i     (act_s),
      .ap_i      (ap_s),
      .close_i   (close_s),
      .open_o    (open_v[b]),
      .closing_o (closing_v[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) illegal_q <= 1'b0;
    else             illegal_q <= bad;
  end

  assign illegal_o   = illegal_q;
  assign bank_open_o = open_v;
  assign mode_o      = mode;
  assign dq_hiz_o    = ~cke_i | (mode != MODE_NORMAL);

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           cmd_i,
  input logic [BA_W-1:0]      ba_i,
  input logic                 cke_i,
  input logic                 illegal_o,
  input logic                 dq_hiz_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [1:0]           mode_o
);

  AST_CKE_LOW_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |-> dq_hiz_o); // R11

  AST_LOW_CKE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> ##1 !illegal_o); // R1

  AST_ACT_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 4'd1 && $past(cke_i) && bank_open_o[ba_i]) |=> illegal_o); // R2

  AST_SREF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && cmd_i == 4'd9 && bank_open_o != '0) |=> mode_o != 2'd2); // R7

  AST_PDOWN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !cke_i && cmd_i == 4'd0) |=> mode_o == 2'd1); // R8

  AST_ILLEGAL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && $past(cke_i)) |-> mode_o == $past(mode_o)); // R12

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BA_W      (BA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .cmd_i       (cmd_i),
  .ba_i        (ba_i),
  .cke_i       (cke_i),
  .illegal_o   (illegal_o),
  .dq_hiz_o    (dq_hiz_o),
  .bank_open_o (bank_open_o),
  .mode_o      (mode_o)
);

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int BURST      = 2;
  localparam int LOCK       = 200;
  localparam int WATCHDOG   = 5000;

  localparam logic [3:0] NOP = 4'd0, ACT = 4'd1, RD = 4'd2, RDA = 4'd3, WR = 4'd4,
                         WRA = 4'd5, PRE = 4'd6, PALL = 4'd7, REF = 4'd8,
                         SREF = 4'd9, SREX = 4'd10, MRS = 4'd11, EMRS = 4'd12,
                         BST = 4'd13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cmd_i = NOP;
  logic [0:0] ba_i = 1'b0;
  logic       cke_i = 1'b1;
  logic       illegal_o, dq_hiz_o;
  logic [1:0] bank_open_o, mode_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit running  = 1'b0;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .ba_i        (ba_i),
    .cke_i       (cke_i),
    .illegal_o   (illegal_o),
    .dq_hiz_o    (dq_hiz_o),
    .bank_open_o (bank_open_o),
    .mode_o      (mode_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_open[2], m_cnt[2];
  int m_mode, m_gate, m_lock, m_rs;
  bit m_ckeq, m_ill;

  always @(posedge clk or negedge rst_n) begin
    int c, b;
    bit k, idle, closing_any, bad, take, rise;
    if (!rst_n) begin
      m_rs = 0; m_mode = 0; m_gate = 0; m_lock = 0; m_ckeq = 0; m_ill = 0;
      m_open[0] = 0; m_open[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      c = int'(cmd_i); b = int'(ba_i); k = cke_i;
      idle = (m_open[0] == 0) && (m_open[1] == 0);
      closing_any = (m_cnt[0] > 0) || (m_cnt[1] > 0);
      bad = 0; take = 0;
      if (m_ckeq) begin
        if (m_gate > 0 || m_mode != 0) bad = (c != 0);
        else begin
          case (c)
            0:            bad = 0;
            1:            bad = (m_open[b] != 0);
            2, 3:         bad = (m_open[b] == 0) || (m_cnt[b] > 0) || (m_lock > 0);
            4, 5:         bad = (m_open[b] == 0) || (m_cnt[b] > 0);
            6, 7:         bad = 0;
            8, 9, 11, 12: bad = !idle;
            10:           bad = 1;
            13:           bad = closing_any;
            default:      bad = 1;
          endcase
          take = !bad && (c != 0);
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (take && (c == 7 || (c == 6 && b == i))) begin
          m_open[i] = 0; m_cnt[i] = 0;
        end else if (take && (c == 3 || c == 5) && b == i) begin
          m_cnt[i] = BURST;
        end else if (take && c == 1 && b == i) begin
          m_open[i] = 1;
        end else if (m_cnt[i] > 0) begin
          m_cnt[i]--;
          if (m_cnt[i] == 0) m_open[i] = 0;
        end
      end
      rise = !m_ckeq && k;
      if (m_mode == 2 && rise) m_lock = LOCK;
      else if (m_lock > 0)     m_lock--;
      if (rise)              m_gate = 2;
      else if (m_gate > 0)   m_gate--;
      case (m_mode)
        0: if (take && c == 9) m_mode = 2; else if (!k) m_mode = 1;
        1: if (k) m_mode = 0;
        default: if (rise) m_mode = 0;
      endcase
      m_ckeq = k;
      m_ill  = bad;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n && !done) begin
      chk("R12 illegal vs model", int'(illegal_o), int'(m_ill));
      chk("R4 banks vs model", int'(bank_open_o), m_open[1] * 2 + m_open[0]);
      chk("R8 mode vs model", int'(mode_o), m_mode);
      chk("R11 hiz vs model", int'(dq_hiz_o), int'(!cke_i || m_mode != 0));
    end
  end

  task automatic cyc(input logic [3:0] c, input logic b, input logic k);
    cmd_i = c; ba_i = b; cke_i = k;
    @(negedge clk); #(Q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); #(Q);
    repeat (3) cyc(NOP, 0, 1);
    // R13 reset state
    chk("R13 illegal", int'(illegal_o), 0);
    chk("R13 banks", int'(bank_open_o), 0);
    chk("R13 mode", int'(mode_o), 0);
    rst_n = 1'b1;
    running = 1'b1;
    cyc(NOP, 0, 1); cyc(NOP, 0, 1);
    chk("R13 sync hold", int'(bank_open_o), 0);
    repeat (3) cyc(NOP, 0, 1);

    cyc(ACT, 0, 1);  chk("R2 act opens", int'(bank_open_o), 1); chk("R2 act ok", int'(illegal_o), 0);
    cyc(ACT, 0, 1);  chk("R2 act open bank", int'(illegal_o), 1); chk("R12 no change", int'(bank_open_o), 1);
    cyc(RD, 1, 1);   chk("R3 read idle bank", int'(illegal_o), 1);
    cyc(RD, 0, 1);   chk("R3 read open bank", int'(illegal_o), 0);
    cyc(ACT, 1, 1);  chk("R2 second bank", int'(bank_open_o), 3);
    cyc(MRS, 0, 1);  chk("R6 mrs open", int'(illegal_o), 1);
    cyc(SREF, 0, 1); chk("R7 sref open", int'(illegal_o), 1); chk("R7 mode kept", int'(mode_o), 0);
    cyc(PRE, 1, 1);  chk("R4 pre", int'(bank_open_o), 1);
    cyc(PRE, 1, 1);  chk("R4 pre idle noop", int'(illegal_o), 0); chk("R4 pre idle banks", int'(bank_open_o), 1);
    cyc(RDA, 0, 1);  chk("R5 rda open", int'(bank_open_o), 1);
    cyc(ACT, 0, 1);  chk("R5 act closing", int'(illegal_o), 1); chk("R5 still open", int'(bank_open_o), 1);
    cyc(BST, 0, 1);  chk("R5 bst closing", int'(illegal_o), 1); chk("R5 closed", int'(bank_open_o), 0);
    cyc(ACT, 0, 1);  chk("R5 reopen", int'(illegal_o), 0);
    cyc(WRA, 0, 1);
    cyc(PRE, 0, 1);  chk("R4 pre cancels close", int'(bank_open_o), 0); chk("R4 pre legal", int'(illegal_o), 0);
    cyc(ACT, 0, 1); cyc(ACT, 1, 1);
    cyc(PALL, 0, 1); chk("R4 pall", int'(bank_open_o), 0);
    cyc(REF, 0, 1);  chk("R6 ref idle", int'(illegal_o), 0);
    cyc(EMRS, 1, 1); chk("R6 emrs idle", int'(illegal_o), 0);

    cyc(NOP, 0, 0);  chk("R8 pdown", int'(mode_o), 1); chk("R11 hiz", int'(dq_hiz_o), 1);
    cyc(ACT, 0, 0);  chk("R1 ignored flag", int'(illegal_o), 0); chk("R1 ignored bank", int'(bank_open_o), 0);
    cyc(ACT, 0, 1);  chk("R1 ignored on rise", int'(bank_open_o), 0); chk("R8 wake", int'(mode_o), 0);
    cyc(ACT, 0, 1);  chk("R9 gate 1", int'(illegal_o), 1); chk("R9 not applied", int'(bank_open_o), 0);
    cyc(ACT, 0, 1);  chk("R9 gate 2", int'(illegal_o), 1);
    cyc(ACT, 0, 1);  chk("R9 open after gate", int'(bank_open_o), 1);
    cyc(NOP, 0, 0);  chk("R8 pdown open bank", int'(mode_o), 1);
    cyc(NOP, 0, 1); cyc(NOP, 0, 1); cyc(NOP, 0, 1);
    cyc(PRE, 0, 1);  chk("R4 closed", int'(bank_open_o), 0);

    cyc(SREF, 0, 0); chk("R7 sref enter", int'(mode_o), 2); chk("R11 hiz sref", int'(dq_hiz_o), 1);
    repeat (3) cyc(NOP, 0, 0);
    cyc(NOP, 0, 1);  chk("R7 sref exit", int'(mode_o), 0);
    cyc(NOP, 0, 1); cyc(NOP, 0, 1);
    cyc(ACT, 0, 1);  chk("R10 act allowed", int'(illegal_o), 0);
    cyc(RD, 0, 1);   chk("R10 read locked early", int'(illegal_o), 1);
    repeat (LOCK - 5) cyc(NOP, 0, 1);
    cyc(RD, 0, 1);   chk("R10 read locked last", int'(illegal_o), 1);
    cyc(RD, 0, 1);   chk("R10 read free", int'(illegal_o), 0);
    cyc(SREX, 0, 1); chk("R7 srex flagged", int'(illegal_o), 1);
    cyc(SREF, 0, 1); chk("R7 sref open bank", int'(illegal_o), 1); chk("R7 sref refused", int'(mode_o), 0);
    cyc(PRE, 0, 1);  chk("R12 pulse ends", int'(illegal_o), 0);
    cyc(SREF, 0, 1); chk("R7 sref cke high", int'(mode_o), 2);
    cyc(ACT, 0, 1);  chk("R7 cmd in sref", int'(illegal_o), 1); chk("R12 act not applied", int'(bank_open_o), 0);
    cyc(NOP, 0, 0);
    cyc(NOP, 0, 1);  chk("R7 exit after low", int'(mode_o), 0);
    repeat (3) cyc(NOP, 0, 1);
    finish_run();
  end

endmodule